// File: doc/BRIEF.md
# Decode-Stage Delayed Branch Unit

This unit produces the fetch address for a five-stage in-order pipeline (fetch, decode/register read, execute, memory, writeback). It owns the program counter and the fetch-to-decode address register. Control transfers are settled in the decode stage by a comparator on two operands that arrive already forwarded. A taken branch or jump changes the fetch address in that same cycle. Once resolved, a branch has nothing left to do in the later stages.

The architecture defines exactly one delay slot. The instruction fetched directly after a branch or jump always executes, whether or not the transfer is taken. As a result no fetched instruction is ever squashed, and control hazards cost zero bubble cycles. A stall input freezes the fetch address and the decode register, and it holds back any redirect. A branch waiting in decode is therefore judged on the operands present in the cycle the stall lifts.

The decoder supplies a two-bit class code, the two operand values, a 16-bit word offset and a 26-bit jump index. The unit returns the fetch address, the address of the instruction held in decode, a flag that marks decode as valid rather than a reset no-op, and a redirect strobe.

Top module: `dslot_branch_unit`

## Requirements
- R1: While `rst_ni` is low, `fetch_pc_o` equals the parameter `RESET_VEC` (default 32'h0000_1000), `dec_valid_o` is 0 and `redirect_o` is 0.
- R2: After reset, decode holds a no-op until the first unstalled clock edge. While `dec_valid_o` is 0 the class code and operands have no effect: `redirect_o` stays 0 and the next fetch address is `fetch_pc_o + 4`.
- R3: Class code 2'b01 is branch-if-equal. With decode valid, no stall and `opa_i == opb_i`, `redirect_o` is 1 in the same cycle. The next `fetch_pc_o` is then the delay-slot address (the current `fetch_pc_o`) plus the sign-extended `br_off_i` shifted left by two.
- R4: Class code 2'b10 is branch-if-not-equal. It takes the same target as R3 when `opa_i != opb_i`.
- R5: When no redirect happens on an unstalled cycle, the next `fetch_pc_o` is the current `fetch_pc_o + 4`. This also covers a branch that is not taken.
- R6: Class code 2'b11 is an unconditional jump. With decode valid and no stall, `redirect_o` is 1. The next fetch address is the top four bits of the delay-slot address, followed by `jmp_idx_i`, followed by two zero bits.
- R7: The delay slot always executes. On the unstalled edge after a branch or jump is decoded, `dec_pc_o` becomes that instruction's address plus 4 and `dec_valid_o` is 1. Once set, `dec_valid_o` never clears outside reset.
- R8: No bubbles. On every unstalled edge, `dec_pc_o` takes the previous `fetch_pc_o` and `dec_valid_o` becomes 1.
- R9: While `stall_i` is 1, `fetch_pc_o`, `dec_pc_o` and `dec_valid_o` keep their values across the edge, and `redirect_o` is 0.
- R10: For class code 2'b00 (any other instruction) the operand values and offsets have no effect. For a jump the operand values have no effect.
- R11: A branch held in decode by a stall is decided on the operand values present in the first cycle with `stall_i` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Freeze fetch address and decode register; block redirect |
| kind_i | input | 2 | Class of the decoded instruction: 00 other, 01 equal branch, 10 not-equal branch, 11 jump |
| opa_i | input | XLEN | First forwarded operand |
| opb_i | input | XLEN | Second forwarded operand |
| br_off_i | input | OFF_W | Signed word offset relative to the delay-slot address |
| jmp_idx_i | input | IDX_W | Jump word index |
| fetch_pc_o | output | XLEN | Address being fetched (the delay slot when decode holds a transfer) |
| dec_pc_o | output | XLEN | Address of the instruction in decode |
| dec_valid_o | output | 1 | Decode holds a real instruction |
| redirect_o | output | 1 | A control transfer is taken this cycle |

## Verification
The checker watches several rules on every clock. It confirms that a stall freezes all state and blocks redirects. It confirms that each unstalled edge moves the fetch address into decode without leaving a gap. It checks that sequential fetch advances by four whenever there is no redirect, and that equal branches, unequal branches and jumps fire under their conditions. Some behaviour depends on program order, and only the bench's scenarios can show it. One is a delay slot that writes a value which the branch at the target then tests. Others are the loop back through a not-equal branch with a negative offset, and branches that sit in decode under a stall while their operands change.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  typedef enum logic [1:0] {
    CTL_NONE = 2'b00,
    CTL_BEQ  = 2'b01,
    CTL_BNE  = 2'b10,
    CTL_JUMP = 2'b11
  } ctl_kind_e;
endpackage

// File: rtl/dslot_cond.sv
module dslot_cond
  import dslot_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CMP_STYLE = 1  // 0: direct compare, 1: xor-reduce
) (
  input  logic            valid_i,
  input  ctl_kind_e       kind_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic            take_o
);
  logic same;

  generate
    if (CMP_STYLE == 0) begin : g_direct
      assign same = (opa_i == opb_i);
    end else begin : g_xor
      logic [XLEN-1:0] diff;
      assign diff = opa_i ^ opb_i;
      assign same = ~|diff;
    end
  endgenerate

  always_comb begin
    take_o = 1'b0;
    if (valid_i) begin
      unique case (kind_i)
        CTL_BEQ:  take_o = same;
        CTL_BNE:  take_o = ~same;
        CTL_JUMP: take_o = 1'b1;
        default:  take_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/dslot_target.sv
module dslot_target
  import dslot_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int IDX_W = 26
) (
  input  logic [XLEN-1:0]  slot_pc_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [IDX_W-1:0] idx_i,
  input  ctl_kind_e        kind_i,
  input  logic             take_i,
  output logic [XLEN-1:0]  npc_o
);
  localparam int EXT_W = XLEN - OFF_W - 2;
  localparam int HI_W  = XLEN - IDX_W - 2;

  logic [XLEN-1:0] seq_pc, br_pc, jmp_pc, off_x;

  assign off_x  = {{EXT_W{off_i[OFF_W-1]}}, off_i, 2'b00};
  assign seq_pc = slot_pc_i + XLEN'(4);
  assign br_pc  = slot_pc_i + off_x;
  assign jmp_pc = {slot_pc_i[XLEN-1 -: HI_W], idx_i, 2'b00};

  always_comb begin
    if (!take_i)                npc_o = seq_pc;
    else if (kind_i == CTL_JUMP) npc_o = jmp_pc;
    else                        npc_o = br_pc;
  end
endmodule

// File: rtl/dslot_pipe_regs.sv
module dslot_pipe_regs #(
  parameter int          XLEN      = 32,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic [XLEN-1:0] npc_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] dec_pc_o,
  output logic            dec_valid_o
);
  logic [XLEN-1:0] pc_q, dec_pc_q;
  logic            dec_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q        <= XLEN'(RESET_VEC);
      dec_pc_q    <= '0;
      dec_valid_q <= 1'b0;
    end else if (!stall_i) begin
      pc_q        <= npc_i;
      dec_pc_q    <= pc_q;
      dec_valid_q <= 1'b1;
    end
  end

  assign pc_o        = pc_q;
  assign dec_pc_o    = dec_pc_q;
  assign dec_valid_o = dec_valid_q;
endmodule

// File: rtl/dslot_branch_unit.sv
module dslot_branch_unit
  import dslot_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          OFF_W     = 16,
  parameter int          IDX_W     = 26,
  parameter int          CMP_STYLE = 1,
  parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  input  logic [1:0]       kind_i,
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  input  logic [OFF_W-1:0] br_off_i,
  input  logic [IDX_W-1:0] jmp_idx_i,
  output logic [XLEN-1:0]  fetch_pc_o,
  output logic [XLEN-1:0]  dec_pc_o,
  output logic             dec_valid_o,
  output logic             redirect_o
);
  ctl_kind_e       kind;
  logic            take, take_ok;
  logic [XLEN-1:0] pc, npc;

  assign kind    = ctl_kind_e'(kind_i);
  assign take_ok = take & ~stall_i;  // redirect waits for the stall to lift

  dslot_cond #(.XLEN(XLEN), .CMP_STYLE(CMP_STYLE)) i_cond (
    .valid_i (dec_valid_o),
    .kind_i  (kind),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .take_o  (take)
  );

  dslot_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_target (
    .slot_pc_i (pc),
    .off_i     (br_off_i),
    .idx_i     (jmp_idx_i),
    .kind_i    (kind),
    .take_i    (take_ok),
    .npc_o     (npc)
  );

  dslot_pipe_regs #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_i     (stall_i),
    .npc_i       (npc),
    .pc_o        (pc),
    .dec_pc_o    (dec_pc_o),
    .dec_valid_o (dec_valid_o)
  );

  assign fetch_pc_o = pc;
  assign redirect_o = take_ok;
endmodule

// File: rtl/dslot_branch_unit_chk.sv
module dslot_branch_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            stall_i,
  input logic [1:0]      kind_i,
  input logic [XLEN-1:0] opa_i,
  input logic [XLEN-1:0] opb_i,
  input logic [XLEN-1:0] fetch_pc_o,
  input logic [XLEN-1:0] dec_pc_o,
  input logic            dec_valid_o,
  input logic            redirect_o
);
  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(fetch_pc_o) && $stable(dec_pc_o) && $stable(dec_valid_o)));

  assert_stall_no_redirect_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !redirect_o);

  assert_no_bubble_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i |=> (dec_valid_o && dec_pc_o == $past(fetch_pc_o)));

  assert_valid_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |=> dec_valid_o);

  assert_noop_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o |-> !redirect_o);

  assert_sequential_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !redirect_o) |=> fetch_pc_o == $past(fetch_pc_o) + XLEN'(4));

  assert_jump_taken_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && dec_valid_o && kind_i == 2'b11) |-> redirect_o);

  assert_beq_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && dec_valid_o && kind_i == 2'b01) |-> (redirect_o == (opa_i == opb_i)));

  assert_bne_taken_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && dec_valid_o && kind_i == 2'b10) |-> (redirect_o == (opa_i != opb_i)));

  assert_other_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 2'b00) |-> !redirect_o);
endmodule

bind dslot_branch_unit dslot_branch_unit_chk #(.XLEN(XLEN)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stall_i     (stall_i),
  .kind_i      (kind_i),
  .opa_i       (opa_i),
  .opb_i       (opb_i),
  .fetch_pc_o  (fetch_pc_o),
  .dec_pc_o    (dec_pc_o),
  .dec_valid_o (dec_valid_o),
  .redirect_o  (redirect_o)
);

// File: tb/test_dslot_branch_unit.sv
module test_dslot_branch_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int OFF_W = 16;
  localparam int IDX_W = 26;
  localparam logic [31:0] RV = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0;
  logic [1:0] kind = 2'b01;
  logic [XLEN-1:0] opa = 32'd3, opb = 32'd3;
  logic [OFF_W-1:0] off = 16'd4;
  logic [IDX_W-1:0] idx = '0;
  logic [XLEN-1:0] fetch_pc, dec_pc;
  logic dec_valid, redirect;

  int checks = 0, fails = 0;
  int hit_1024 = 0, hit_102c = 0, hit_1100 = 0, hit_1000 = 0, hit_stall_br = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dslot_branch_unit i_dslot_branch_unit (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .kind_i(kind),
    .opa_i(opa), .opb_i(opb), .br_off_i(off), .jmp_idx_i(idx),
    .fetch_pc_o(fetch_pc), .dec_pc_o(dec_pc), .dec_valid_o(dec_valid),
    .redirect_o(redirect)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // bench register state written by delay-slot instructions
  int r3 = 0;

  // program image: class, operands, offset, index, register effect
  task automatic fetch_prog(input logic [31:0] pc, input int cyc,
                            output logic [1:0] k, output logic [31:0] a, output logic [31:0] b,
                            output logic [15:0] o, output logic [25:0] j, output int wr3);
    k = 2'b00; a = 32'(cyc); b = 32'(cyc + 1); o = 16'h7FFF; j = 26'h3FF_FFFF; wr3 = -1;
    case (pc)
      32'h1000: wr3 = 0;
      32'h1004: begin k = 2'b01; a = 3; b = 3; o = 16'd4; end
      32'h1008: wr3 = 7;                                  // delay slot of the branch
      32'h1018: begin k = 2'b01; a = 32'(r3); b = 7; o = 16'd2; end
      32'h1024: begin k = 2'b10; a = 5; b = 5; o = 16'd8; end
      32'h102C: begin k = 2'b11; j = 26'h440; end
      32'h1100: begin k = 2'b10; a = 1; b = 2; o = 16'hFFBF; end
      default: ;
    endcase
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] m_fpc, m_dpc, e_npc;
    bit m_dval, e_red, prev_stall_br;
    logic [1:0] k; logic [31:0] a, b; logic [15:0] o; logic [25:0] j; int w;
    string tag;

    repeat (3) @(negedge clk);
    check(fetch_pc == RV, "R1 fetch", fetch_pc, RV);
    check(dec_valid == 1'b0, "R1 valid", dec_valid, 0);
    check(redirect == 1'b0, "R1 redirect", redirect, 0);
    rst_n = 1'b1;
    m_fpc = RV; m_dpc = 0; m_dval = 0; prev_stall_br = 0;

    for (int cyc = 0; cyc < 300; cyc++) begin
      if (cyc > 0) @(negedge clk);
      check(fetch_pc == m_fpc, "R5 fetch_pc", fetch_pc, m_fpc);
      check(dec_pc == m_dpc, "R8 dec_pc", dec_pc, m_dpc);
      check(dec_valid == m_dval, "R7 dec_valid", dec_valid, m_dval);

      stall = (cyc % 6 == 4) || (cyc % 13 == 9);
      if (!m_dval) begin
        k = 2'b01; a = 9; b = 9; o = 16'd1; j = '0; w = -1;  // would be taken if valid
      end else begin
        fetch_prog(m_dpc, cyc, k, a, b, o, j, w);
        if (stall && (k == 2'b01 || k == 2'b10)) begin
          b = ~a;           // wrong operands during the stall
          if (k == 2'b10) b = a;
          hit_stall_br++;
        end
      end
      kind = k; opa = a; opb = b; off = o; idx = j;
      #1;

      e_red = 0;
      if (m_dval && !stall) begin
        if (k == 2'b01) e_red = (a == b);
        else if (k == 2'b10) e_red = (a != b);
        else if (k == 2'b11) e_red = 1;
      end
      if (!m_dval) tag = "R2";
      else if (stall) tag = "R9";
      else if (prev_stall_br) tag = "R11";
      else if (k == 2'b01) tag = "R3";
      else if (k == 2'b10) tag = "R4";
      else if (k == 2'b11) tag = "R6";
      else tag = "R10";
      check(redirect == e_red, {tag, " redirect"}, redirect, e_red);

      if (!stall) begin
        if (!e_red) e_npc = m_fpc + 4;
        else if (k == 2'b11) e_npc = {m_fpc[31:28], j, 2'b00};
        else e_npc = m_fpc + {{14{o[15]}}, o, 2'b00};
        if (m_dval) begin
          if (m_dpc == 32'h1024) hit_1024++;
          if (m_dpc == 32'h102C) hit_102c++;
          if (m_dpc == 32'h1100) hit_1100++;
          if (m_dpc == 32'h1000) hit_1000++;
        end
        if (w >= 0) r3 = w;
        m_dpc = m_fpc; m_fpc = e_npc; m_dval = 1;
      end
      prev_stall_br = stall && m_dval && (k == 2'b01 || k == 2'b10);
    end

    check(hit_1024 > 0, "R7 delay-slot write seen by target branch", hit_1024, 1);
    check(hit_102c > 0, "R5 not-taken branch falls through", hit_102c, 1);
    check(hit_1100 > 0, "R6 jump target reached", hit_1100, 1);
    check(hit_1000 > 1, "R4 taken backward branch loops", hit_1000, 2);
    check(hit_stall_br > 0, "R11 branch stalled in decode", hit_stall_br, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule